// File: doc/BRIEF.md
# Memory-Mapped Device DMA Agent

This block sits on the device side of a DMA engine. It takes one transfer descriptor at a time and moves the data between a host-facing stream port and a user AXI4 memory-mapped subordinate. A descriptor names a direction, a device address, a host address and a byte count. For a device write, the agent asks the upstream arbiter for host data, buffers the returned beats and writes them to the subordinate as AXI4 INCR bursts. For a device read, it first announces a host write to the arbiter, then reads the subordinate and forwards the returned beats as a stream toward the host.

Every AXI4 transaction carries the same ID, so responses always arrive in order and the agent has no reorder logic. A descriptor is split into bursts of at most 16 beats, and no burst crosses a 4 KB page. Only aligned descriptors are carried out. A misaligned or empty descriptor is retired at once with an alignment flag. A soft reset request makes the agent finish any AXI burst already in flight, discard its buffer and any host input, return to defaults and raise a done flag.

All stream ports use valid/ready. A beat moves on a clock edge where both valid and ready are high. A source that raises valid keeps it high, with its payload stable, until the beat is taken. The agent's descriptor, command, host-output and AXI channels all follow this rule. The host input port is held off (hin_ready low) while the internal buffer is full. The AXI read data channel is held off the same way.

Top module: `mm_dma_agent`

## Requirements
- R1: Each accepted aligned descriptor produces exactly one command beat before any AXI address beat. The command carries the descriptor's host address and byte count. cmd_is_read is 1 for desc_dir=0 (device write, so host data is requested) and 0 for desc_dir=1 (device read, so a host write is announced).
- R2: On a device write, host input beats are written to the subordinate in arrival order at consecutive beat addresses from the device address. wstrb is all ones and wlast is high exactly on the final beat of each burst.
- R3: On a device read, the beats read from the subordinate leave on hout in address order. hout_last is high only on the final beat of the descriptor. hout_data is held while hout_ready is low.
- R4: awid and arid always equal the AXI_ID parameter (default 0). The burst type is INCR (01), and awsize/arsize equals log2 of the beat width in bytes (3 for 64-bit data).
- R5: A descriptor is covered by bursts in ascending address order. Each burst is the smallest of 16 beats, the beats left, and the beats left before the next 4 KB boundary.
- R6: A descriptor is retired with cpl_status[1]=1 and no command or AXI traffic if any of these holds: the device address is not a multiple of the beat size, the host address is not a multiple of the beat size, the byte count is not a multiple of the beat size, or the byte count is zero.
- R7: cpl_valid pulses for exactly one cycle per completed descriptor. For a write this follows the last write response; for a read it follows the last hout beat. cpl_status[0] is 1 if any write or read response of that descriptor had bit 1 set (SLVERR or DECERR).
- R8: After a soft_rst_req pulse, desc_ready stays low until soft_rst_done rises. A burst in flight is finished, with remaining write beats sent with wstrb=0. Buffered data and host input beats offered meanwhile are discarded. The aborted descriptor gets no completion. soft_rst_done then stays 1 until the next request.
- R9: After hard reset, desc_ready is 1, soft_rst_done is 0, and cmd_valid, awvalid, arvalid, hout_valid and cpl_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hard reset |
| soft_rst_req | input | 1 | One-cycle soft reset request |
| soft_rst_done | output | 1 | Soft reset finished; cleared by the next request |
| desc_valid | input | 1 | Descriptor valid |
| desc_ready | output | 1 | Descriptor accepted when high with valid |
| desc_dir | input | 1 | 0 = device write, 1 = device read |
| desc_dev_addr | input | ADDR_W | Device-side byte address |
| desc_host_addr | input | ADDR_W | Host-side byte address |
| desc_bytes | input | LEN_W | Transfer length in bytes |
| cmd_valid | output | 1 | Command beat valid |
| cmd_ready | input | 1 | Arbiter takes command |
| cmd_is_read | output | 1 | 1 = host read request, 0 = host write request |
| cmd_host_addr | output | ADDR_W | Host address of the request |
| cmd_bytes | output | LEN_W | Byte count of the request |
| hin_valid | input | 1 | Host data beat valid |
| hin_ready | output | 1 | Agent takes host data |
| hin_data | input | DATA_W | Host data beat |
| hout_valid | output | 1 | Outgoing data beat valid |
| hout_ready | input | 1 | Arbiter takes outgoing beat |
| hout_data | output | DATA_W | Outgoing data beat |
| hout_last | output | 1 | Final beat of the descriptor |
| awvalid | output | 1 | AXI write address valid |
| awready | input | 1 | AXI write address ready |
| awid | output | ID_W | Write ID (fixed) |
| awaddr | output | ADDR_W | Write burst address |
| awlen | output | 8 | Write beats minus one |
| awsize | output | 3 | Write beat size code |
| awburst | output | 2 | Write burst type |
| wvalid | output | 1 | AXI write data valid |
| wready | input | 1 | AXI write data ready |
| wdata | output | DATA_W | Write data |
| wstrb | output | DATA_W/8 | Write byte strobes |
| wlast | output | 1 | Last beat of write burst |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| bresp | input | 2 | Write response code |
| arvalid | output | 1 | AXI read address valid |
| arready | input | 1 | AXI read address ready |
| arid | output | ID_W | Read ID (fixed) |
| araddr | output | ADDR_W | Read burst address |
| arlen | output | 8 | Read beats minus one |
| arsize | output | 3 | Read beat size code |
| arburst | output | 2 | Read burst type |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |
| rdata | input | DATA_W | Read data |
| rresp | input | 2 | Read response code |
| rlast | input | 1 | Last beat of read burst |
| cpl_valid | output | 1 | One-cycle completion pulse |
| cpl_status | output | 2 | [1] alignment reject, [0] bus error |

## Verification
The main data paths are driven with these descriptors:
- A single short burst, which shows the basic packing and the command fields.
- A long transfer that splits into several full 16-beat bursts plus a remainder, which separates the 16-beat cap from the remaining-length limit.
- Start addresses just below a 4 KB page, one that ends exactly on the boundary and one that crosses it, which separate the page limit from the other two limits.
- A device read run with a toggling hout_ready, which shows that data is held under back-pressure and that the last flag is placed only at the descriptor end.
- Error-region addresses, which separate bus-error reporting from a clean completion.
- Three kinds of misaligned descriptors, which show that rejection causes no traffic.
- A soft reset issued mid-burst with host data starved, and host junk offered during the drain. This shows the null-strobe finish, the discard of junk, and that the agent works normally afterwards.

// File: rtl/mm_dma_pkg.sv
package mm_dma_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD, ST_AW, ST_W, ST_B, ST_AR, ST_R, ST_FIN, ST_CPL, ST_DRAIN
  } agent_state_t;

  localparam logic [1:0] BURST_INCR = 2'b01;

  function automatic logic resp_is_err(input logic [1:0] resp);
    return resp[1];
  endfunction
endpackage

// File: rtl/mm_dma_fifo.sv
module mm_dma_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0] store [DEPTH];
  logic [PW:0]  wp, rp;

  assign empty = (wp == rp);
  assign full  = (wp[PW] != rp[PW]) && (wp[PW-1:0] == rp[PW-1:0]);
  assign dout  = store[rp[PW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else if (clr) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full && !clr) store[wp[PW-1:0]] <= din;
  end
endmodule

// File: rtl/mm_dma_burst_plan.sv
module mm_dma_burst_plan #(
  parameter int LEN_W      = 16,
  parameter int BEAT_BYTES = 8,
  parameter int MAX_BEATS  = 16,
  parameter int PAGE_BYTES = 4096,
  localparam int PAGE_W    = $clog2(PAGE_BYTES),
  localparam int OFF_W     = $clog2(BEAT_BYTES),
  localparam int BCNT_W    = $clog2(MAX_BEATS + 1)
) (
  input  logic [PAGE_W-1:0] page_off,
  input  logic [LEN_W-1:0]  rem_beats,
  output logic [BCNT_W-1:0] beats
);
  logic [31:0] page_left, cap;

  always_comb begin
    page_left = (32'(PAGE_BYTES) - 32'(page_off)) >> OFF_W;
    cap = 32'(MAX_BEATS);
    if (32'(rem_beats) < cap) cap = 32'(rem_beats);
    if (page_left < cap)      cap = page_left;
    beats = BCNT_W'(cap);
  end
endmodule

// File: rtl/mm_dma_agent.sv
module mm_dma_agent
  import mm_dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int LEN_W      = 16,
  parameter int ID_W       = 4,
  parameter int AXI_ID     = 0,
  parameter int MAX_BEATS  = 16,
  parameter int FIFO_DEPTH = 32,
  localparam int BB        = DATA_W / 8,
  localparam int OFF_W     = $clog2(BB),
  localparam int BCNT_W    = $clog2(MAX_BEATS + 1),
  localparam int PAGE_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst_req,
  output logic              soft_rst_done,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic              desc_dir,
  input  logic [ADDR_W-1:0] desc_dev_addr,
  input  logic [ADDR_W-1:0] desc_host_addr,
  input  logic [LEN_W-1:0]  desc_bytes,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_is_read,
  output logic [ADDR_W-1:0] cmd_host_addr,
  output logic [LEN_W-1:0]  cmd_bytes,
  input  logic              hin_valid,
  output logic              hin_ready,
  input  logic [DATA_W-1:0] hin_data,
  output logic              hout_valid,
  input  logic              hout_ready,
  output logic [DATA_W-1:0] hout_data,
  output logic              hout_last,
  output logic              awvalid,
  input  logic              awready,
  output logic [ID_W-1:0]   awid,
  output logic [ADDR_W-1:0] awaddr,
  output logic [7:0]        awlen,
  output logic [2:0]        awsize,
  output logic [1:0]        awburst,
  output logic              wvalid,
  input  logic              wready,
  output logic [DATA_W-1:0] wdata,
  output logic [BB-1:0]     wstrb,
  output logic              wlast,
  input  logic              bvalid,
  output logic              bready,
  input  logic [1:0]        bresp,
  output logic              arvalid,
  input  logic              arready,
  output logic [ID_W-1:0]   arid,
  output logic [ADDR_W-1:0] araddr,
  output logic [7:0]        arlen,
  output logic [2:0]        arsize,
  output logic [1:0]        arburst,
  input  logic              rvalid,
  output logic              rready,
  input  logic [DATA_W-1:0] rdata,
  input  logic [1:0]        rresp,
  input  logic              rlast,
  output logic              cpl_valid,
  output logic [1:0]        cpl_status
);
  agent_state_t      state;
  logic              dir_rd;
  logic [ADDR_W-1:0] dev_addr, host_addr;
  logic [LEN_W-1:0]  len_bytes, rem_beats, out_left;
  logic [BCNT_W-1:0] wcnt, plan_beats;
  logic              err_bus, err_align, rst_pend;

  logic              f_push, f_pop, f_empty, f_full, f_clr;
  logic [DATA_W-1:0] f_din, f_dout;

  logic desc_fire, misaligned, rst_hit, last_burst;
  logic aw_fire, w_fire, b_fire, ar_fire, r_fire, hin_fire, hout_fire;

  mm_dma_burst_plan #(
    .LEN_W(LEN_W), .BEAT_BYTES(BB), .MAX_BEATS(MAX_BEATS), .PAGE_BYTES(1 << PAGE_W)
  ) u_plan (
    .page_off (dev_addr[PAGE_W-1:0]),
    .rem_beats(rem_beats),
    .beats    (plan_beats)
  );

  mm_dma_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(f_clr),
    .push(f_push), .din(f_din), .pop(f_pop),
    .dout(f_dout), .empty(f_empty), .full(f_full)
  );

  // descriptor intake and misalignment check
  assign desc_ready = (state == ST_IDLE) && !rst_pend && !soft_rst_req;
  assign desc_fire  = desc_valid && desc_ready;
  assign misaligned = (|desc_dev_addr[OFF_W-1:0]) || (|desc_host_addr[OFF_W-1:0]) ||
                      (|desc_bytes[OFF_W-1:0]) || (desc_bytes == '0);
  assign rst_hit    = rst_pend || soft_rst_req;
  assign last_burst = (rem_beats == LEN_W'(plan_beats));

  // command packet toward the arbiter
  assign cmd_valid     = (state == ST_CMD);
  assign cmd_is_read   = !dir_rd;
  assign cmd_host_addr = host_addr;
  assign cmd_bytes     = len_bytes;

  // AXI address channels, fixed ID
  assign awvalid = (state == ST_AW);
  assign arvalid = (state == ST_AR);
  assign awid    = ID_W'(AXI_ID);
  assign arid    = ID_W'(AXI_ID);
  assign awaddr  = dev_addr;
  assign araddr  = dev_addr;
  assign awlen   = 8'(plan_beats) - 8'd1;
  assign arlen   = 8'(plan_beats) - 8'd1;
  assign awsize  = 3'(OFF_W);
  assign arsize  = 3'(OFF_W);
  assign awburst = BURST_INCR;
  assign arburst = BURST_INCR;

  // write data: null beats once a soft reset is pending
  assign wvalid = (state == ST_W) && (rst_pend || !f_empty);
  assign wdata  = rst_pend ? '0 : f_dout;
  assign wstrb  = rst_pend ? '0 : '1;
  assign wlast  = (wcnt == BCNT_W'(1));
  assign bready = (state == ST_B);
  assign rready = (state == ST_R) && (rst_pend || !f_full);

  // host-facing data streams
  assign hin_ready  = (state == ST_DRAIN) ||
                      (!dir_rd && !rst_pend && !f_full &&
                       (state inside {ST_AW, ST_W, ST_B}));
  assign hout_valid = dir_rd && !f_empty && (state inside {ST_AR, ST_R, ST_FIN});
  assign hout_data  = f_dout;
  assign hout_last  = (out_left == LEN_W'(1));

  assign aw_fire   = awvalid && awready;
  assign w_fire    = wvalid && wready;
  assign b_fire    = bvalid && bready;
  assign ar_fire   = arvalid && arready;
  assign r_fire    = rvalid && rready;
  assign hin_fire  = hin_valid && hin_ready;
  assign hout_fire = hout_valid && hout_ready;

  assign f_clr  = (state == ST_DRAIN);
  assign f_push = (hin_fire && state != ST_DRAIN) || (r_fire && !rst_pend);
  assign f_din  = dir_rd ? rdata : hin_data;
  assign f_pop  = (w_fire && !rst_pend) || hout_fire;

  assign cpl_valid  = (state == ST_CPL);
  assign cpl_status = {err_align, err_bus};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      dir_rd        <= 1'b0;
      dev_addr      <= '0;
      host_addr     <= '0;
      len_bytes     <= '0;
      rem_beats     <= '0;
      out_left      <= '0;
      wcnt          <= '0;
      err_bus       <= 1'b0;
      err_align     <= 1'b0;
      rst_pend      <= 1'b0;
      soft_rst_done <= 1'b0;
    end else begin
      if (soft_rst_req) begin
        rst_pend      <= 1'b1;
        soft_rst_done <= 1'b0;
      end
      if (hout_fire) out_left <= out_left - 1'b1;

      case (state)
        ST_IDLE: begin
          if (rst_pend) begin
            state <= ST_DRAIN;
          end else if (desc_fire) begin
            dir_rd    <= desc_dir;
            dev_addr  <= desc_dev_addr;
            host_addr <= desc_host_addr;
            len_bytes <= desc_bytes;
            rem_beats <= desc_bytes >> OFF_W;
            out_left  <= desc_bytes >> OFF_W;
            err_bus   <= 1'b0;
            err_align <= misaligned;
            state     <= misaligned ? ST_CPL : ST_CMD;
          end
        end
        ST_CMD: begin
          if (cmd_ready) begin
            if (rst_hit)     state <= ST_DRAIN;
            else if (dir_rd) state <= ST_AR;
            else             state <= ST_AW;
          end
        end
        ST_AW: begin
          if (aw_fire) begin
            wcnt  <= plan_beats;
            state <= ST_W;
          end
        end
        ST_W: begin
          if (w_fire) begin
            wcnt <= wcnt - 1'b1;
            if (wlast) state <= ST_B;
          end
        end
        ST_B: begin
          if (b_fire) begin
            if (resp_is_err(bresp)) err_bus <= 1'b1;
            dev_addr  <= dev_addr + (ADDR_W'(plan_beats) << OFF_W);
            rem_beats <= rem_beats - LEN_W'(plan_beats);
            if (rst_hit)         state <= ST_DRAIN;
            else if (last_burst) state <= ST_CPL;
            else                 state <= ST_AW;
          end
        end
        ST_AR: begin
          if (ar_fire) state <= ST_R;
        end
        ST_R: begin
          if (r_fire) begin
            if (resp_is_err(rresp)) err_bus <= 1'b1;
            if (rlast) begin
              dev_addr  <= dev_addr + (ADDR_W'(plan_beats) << OFF_W);
              rem_beats <= rem_beats - LEN_W'(plan_beats);
              if (rst_hit)         state <= ST_DRAIN;
              else if (last_burst) state <= ST_FIN;
              else                 state <= ST_AR;
            end
          end
        end
        ST_FIN: begin
          if (rst_hit)                                                state <= ST_DRAIN;
          else if (out_left == '0 || (hout_fire && hout_last))        state <= ST_CPL;
        end
        ST_CPL: begin
          err_bus   <= 1'b0;
          err_align <= 1'b0;
          state     <= ST_IDLE;
        end
        ST_DRAIN: begin
          if (!hin_valid) begin
            dir_rd    <= 1'b0;
            dev_addr  <= '0;
            host_addr <= '0;
            len_bytes <= '0;
            rem_beats <= '0;
            out_left  <= '0;
            wcnt      <= '0;
            err_bus   <= 1'b0;
            err_align <= 1'b0;
            state     <= ST_IDLE;
            if (!soft_rst_req) begin
              rst_pend      <= 1'b0;
              soft_rst_done <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mm_dma_agent_chk.sv
module mm_dma_agent_chk #(
  parameter int ADDR_W    = 32,
  parameter int ID_W      = 4,
  parameter int AXI_ID    = 0,
  parameter int MAX_BEATS = 16,
  parameter int DATA_W    = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst_req,
  input logic              soft_rst_done,
  input logic              desc_ready,
  input logic              awvalid,
  input logic              awready,
  input logic [ID_W-1:0]   awid,
  input logic [ADDR_W-1:0] awaddr,
  input logic [7:0]        awlen,
  input logic              arvalid,
  input logic [ID_W-1:0]   arid,
  input logic [ADDR_W-1:0] araddr,
  input logic [7:0]        arlen,
  input logic              wvalid,
  input logic              wready,
  input logic              cpl_valid
);
  localparam int OFF_W = $clog2(DATA_W / 8);

  logic pend;
  always_ff @(posedge clk) begin
    if (!rst_n)                           pend <= 1'b0;
    else if (soft_rst_req)                pend <= 1'b1;
    else if (soft_rst_done)               pend <= 1'b0;
  end

  // R4
  aw_fixed_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid |-> (awid == ID_W'(AXI_ID)));
  // R4
  ar_fixed_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid |-> (arid == ID_W'(AXI_ID)));
  // R5
  aw_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid |-> (awlen < 8'(MAX_BEATS)) &&
      ((32'(awaddr[11:0]) + ((32'(awlen) + 32'd1) << OFF_W)) <= 32'd4096));
  // R5
  ar_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid |-> (arlen < 8'(MAX_BEATS)) &&
      ((32'(araddr[11:0]) + ((32'(arlen) + 32'd1) << OFF_W)) <= 32'd4096));
  // R5
  aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && !awready) |=> (awvalid && $stable(awaddr) && $stable(awlen)));
  // R2
  w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid && !wready) |=> wvalid);
  // R8
  rst_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !soft_rst_done) |-> !desc_ready);
  // R8
  rst_no_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !soft_rst_done) |-> !cpl_valid);
  // R7
  cpl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |=> !cpl_valid);
endmodule

bind mm_dma_agent mm_dma_agent_chk #(
  .ADDR_W(ADDR_W), .ID_W(ID_W), .AXI_ID(AXI_ID), .MAX_BEATS(MAX_BEATS), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/mm_dma_agent_tb.sv
`timescale 1ns/1ps
module mm_dma_agent_tb;
  localparam int ADDR_W = 32, DATA_W = 64, LEN_W = 16, ID_W = 4;
  localparam logic [31:0] ERR_BASE = 32'h1800;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic soft_rst_req = 0, soft_rst_done;
  logic desc_valid = 0, desc_ready, desc_dir = 0;
  logic [ADDR_W-1:0] desc_dev_addr = '0, desc_host_addr = '0;
  logic [LEN_W-1:0] desc_bytes = '0;
  logic cmd_valid, cmd_ready = 1, cmd_is_read;
  logic [ADDR_W-1:0] cmd_host_addr;
  logic [LEN_W-1:0] cmd_bytes;
  logic hin_valid = 0, hin_ready;
  logic [DATA_W-1:0] hin_data = '0;
  logic hout_valid, hout_ready = 1, hout_last;
  logic [DATA_W-1:0] hout_data;
  logic awvalid, awready, wvalid, wready, wlast, bvalid, bready;
  logic [ID_W-1:0] awid, arid;
  logic [ADDR_W-1:0] awaddr, araddr;
  logic [7:0] awlen, arlen;
  logic [2:0] awsize, arsize;
  logic [1:0] awburst, arburst, bresp, rresp;
  logic [DATA_W-1:0] wdata, rdata;
  logic [7:0] wstrb;
  logic arvalid, arready, rvalid, rready, rlast;
  logic cpl_valid;
  logic [1:0] cpl_status;

  mm_dma_agent u_dut (.*);

  int tests = 0, fails = 0;
  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // subordinate model
  logic [63:0] mem [1024];
  logic        wb, werr;
  logic [31:0] wa, ra;
  logic [7:0]  rc;
  function automatic logic [63:0] pat_mem(input int i);
    return {16'hC0DE, 16'(i), 32'(i) * 32'd7 + 32'h55};
  endfunction
  function automatic logic [63:0] pat_host(input int seed, input int i);
    return {8'hA5, 8'(seed), 16'h0, 32'(i)};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      awready <= 0; wready <= 0; bvalid <= 0; bresp <= 0; wb <= 0; werr <= 0; wa <= 0;
      arready <= 0; rvalid <= 0; rlast <= 0; rresp <= 0; rdata <= 0; ra <= 0; rc <= 0;
    end else begin
      if (awvalid && awready) begin
        awready <= 0; wb <= 1; wready <= 1; wa <= awaddr; werr <= (awaddr >= ERR_BASE);
      end else awready <= !wb && !bvalid;
      if (wvalid && wready) begin
        if (wstrb != 0) mem[wa[12:3]] <= wdata;
        wa <= wa + 8;
        if (wlast) begin wb <= 0; wready <= 0; bvalid <= 1; bresp <= werr ? 2'b10 : 2'b00; end
      end
      if (bvalid && bready) bvalid <= 0;
      if (arvalid && arready) begin
        arready <= 0; ra <= araddr; rc <= arlen; rvalid <= 1;
        rdata <= mem[araddr[12:3]]; rlast <= (arlen == 0);
        rresp <= (araddr >= ERR_BASE) ? 2'b10 : 2'b00;
      end else if (rvalid && rready) begin
        if (rlast) rvalid <= 0;
        else begin
          ra <= ra + 8; rdata <= mem[ra[12:3] + 10'd1]; rc <= rc - 1; rlast <= (rc == 1);
        end
      end else if (!rvalid) arready <= 1;
    end
  end

  // monitors
  logic [31:0] aw_a [64], ar_a [64];
  logic [7:0]  aw_l [64], ar_l [64];
  logic [63:0] ho_d [64];
  logic        ho_l [64];
  int aw_n = 0, ar_n = 0, ho_n = 0, cmd_n = 0, cpl_n = 0;
  int id_bad = 0, wlast_bad = 0, strb_bad = 0, w_idx = 0;
  logic [7:0] cur_len = 0;
  logic last_cmd_rd;
  logic [31:0] last_cmd_addr;
  logic [15:0] last_cmd_bytes;
  logic [1:0] last_stat;
  bit soft_mode = 0, bp = 0;

  always @(posedge clk) if (rst_n) begin
    if (awvalid && (awid != 0 || awsize != 3 || awburst != 2'b01)) id_bad <= id_bad + 1;
    if (arvalid && (arid != 0 || arsize != 3 || arburst != 2'b01)) id_bad <= id_bad + 1;
    if (awvalid && awready) begin
      aw_a[aw_n % 64] <= awaddr; aw_l[aw_n % 64] <= awlen; aw_n <= aw_n + 1; cur_len <= awlen;
    end
    if (arvalid && arready) begin
      ar_a[ar_n % 64] <= araddr; ar_l[ar_n % 64] <= arlen; ar_n <= ar_n + 1;
    end
    if (wvalid && wready) begin
      if (wlast != (w_idx == int'(cur_len))) wlast_bad <= wlast_bad + 1;
      if (wstrb != 8'hFF && !soft_mode) strb_bad <= strb_bad + 1;
      w_idx <= wlast ? 0 : w_idx + 1;
    end
    if (hout_valid && hout_ready) begin
      ho_d[ho_n % 64] <= hout_data; ho_l[ho_n % 64] <= hout_last; ho_n <= ho_n + 1;
    end
    if (cmd_valid && cmd_ready) begin
      cmd_n <= cmd_n + 1; last_cmd_rd <= cmd_is_read;
      last_cmd_addr <= cmd_host_addr; last_cmd_bytes <= cmd_bytes;
    end
    if (cpl_valid) begin cpl_n <= cpl_n + 1; last_stat <= cpl_status; end
  end

  always @(negedge clk) hout_ready <= bp ? ~hout_ready : 1'b1;

  task automatic send_desc(input bit dir, input logic [31:0] dev, input logic [31:0] host,
                           input logic [15:0] bytes);
    bit took;
    @(negedge clk);
    desc_valid = 1; desc_dir = dir; desc_dev_addr = dev; desc_host_addr = host; desc_bytes = bytes;
    took = 0;
    for (int t = 0; t < 2000 && !took; t++) begin
      #1 took = desc_ready;
      @(negedge clk);
    end
    desc_valid = 0;
  endtask

  task automatic push_host(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      bit took = 0;
      for (int t = 0; t < 4000 && !took; t++) begin
        @(negedge clk);
        hin_valid = 1; hin_data = pat_host(seed, i);
        #1 took = hin_ready;
        @(posedge clk);
      end
    end
    @(negedge clk);
    hin_valid = 0;
  endtask

  task automatic wait_cpl(input int prev);
    for (int t = 0; t < 4000 && cpl_n == prev; t++) @(negedge clk);
  endtask

  task automatic check_bursts(input bit rd, input int base, input logic [31:0] addr,
                              input int beats, input string req);
    int k = base;
    while (beats > 0) begin
      int pg = (4096 - int'(addr[11:0])) / 8;
      int b = beats < 16 ? beats : 16;
      if (pg < b) b = pg;
      check((rd ? ar_a[k % 64] : aw_a[k % 64]) == addr, req, "burst address",
            rd ? ar_a[k % 64] : aw_a[k % 64], addr);
      check((rd ? ar_l[k % 64] : aw_l[k % 64]) == 8'(b - 1), req, "burst length",
            rd ? ar_l[k % 64] : aw_l[k % 64], 64'(b - 1));
      addr += 32'(b * 8); beats -= b; k++;
    end
    check((rd ? ar_n : aw_n) == k, req, "burst count", rd ? ar_n : aw_n, k);
  endtask

  task automatic t_reset();
    #1;
    check(desc_ready && !soft_rst_done && !cmd_valid && !awvalid && !arvalid && !hout_valid && !cpl_valid,
          "R9", "reset outputs",
          {desc_ready, soft_rst_done, cmd_valid, awvalid, arvalid, hout_valid, cpl_valid}, 7'b1000000);
  endtask

  task automatic t_write(input logic [31:0] dev, input int beats, input int seed,
                         input logic [1:0] exp_stat);
    int c0 = cmd_n, a0 = aw_n, p0 = cpl_n;
    logic [31:0] host = 32'h8000_0000 + 32'(seed * 256);
    fork
      send_desc(0, dev, host, 16'(beats * 8));
      push_host(beats, seed);
    join
    wait_cpl(p0);
    @(negedge clk);
    check(cmd_n == c0 + 1 && last_cmd_rd == 1, "R1", "write cmd kind", {31'(cmd_n - c0), last_cmd_rd}, 64'h3);
    check(last_cmd_addr == host && last_cmd_bytes == 16'(beats * 8), "R1", "write cmd fields",
          {last_cmd_addr, last_cmd_bytes}, {host, 16'(beats * 8)});
    check_bursts(0, a0, dev, beats, "R5");
    if (exp_stat == 0)
      for (int i = 0; i < beats; i++)
        check(mem[dev[12:3] + 10'(i)] == pat_host(seed, i), "R2", "written beat",
              mem[dev[12:3] + 10'(i)], pat_host(seed, i));
    check(cpl_n == p0 + 1 && last_stat == exp_stat, "R7", "write completion",
          {30'(cpl_n - p0), last_stat}, {30'd1, exp_stat});
  endtask

  task automatic t_read(input logic [31:0] dev, input int beats, input bit backp,
                        input logic [1:0] exp_stat);
    int c0 = cmd_n, a0 = ar_n, p0 = cpl_n, h0 = ho_n, lasts = 0;
    bp = backp;
    send_desc(1, dev, 32'h9000_0000, 16'(beats * 8));
    wait_cpl(p0);
    bp = 0;
    @(negedge clk);
    check(cmd_n == c0 + 1 && last_cmd_rd == 0, "R1", "read cmd kind", {31'(cmd_n - c0), last_cmd_rd}, 64'h2);
    check_bursts(1, a0, dev, beats, "R5");
    check(ho_n == h0 + beats, "R3", "hout beat count", ho_n - h0, beats);
    for (int i = 0; i < beats; i++) begin
      check(ho_d[(h0 + i) % 64] == pat_mem(int'(dev[12:3]) + i), "R3", "hout data",
            ho_d[(h0 + i) % 64], pat_mem(int'(dev[12:3]) + i));
      if (ho_l[(h0 + i) % 64]) lasts++;
    end
    check(lasts == 1 && ho_l[(h0 + beats - 1) % 64], "R3", "hout_last placement", lasts, 1);
    check(cpl_n == p0 + 1 && last_stat == exp_stat, "R7", "read completion",
          {30'(cpl_n - p0), last_stat}, {30'd1, exp_stat});
  endtask

  task automatic t_align(input logic [31:0] dev, input logic [31:0] host, input logic [15:0] bytes);
    int c0 = cmd_n, a0 = aw_n, r0 = ar_n, p0 = cpl_n;
    send_desc(0, dev, host, bytes);
    wait_cpl(p0);
    repeat (4) @(negedge clk);
    check(cpl_n == p0 + 1 && last_stat == 2'b10, "R6", "reject status", {30'(cpl_n - p0), last_stat}, {30'd1, 2'b10});
    check(cmd_n == c0 && aw_n == a0 && ar_n == r0, "R6", "no traffic",
          (cmd_n - c0) + (aw_n - a0) + (ar_n - r0), 0);
  endtask

  task automatic t_softrst();
    int p0 = cpl_n;
    bit done = 0;
    soft_mode = 1;
    fork
      send_desc(0, 32'h200, 32'h8800_0000, 16'd64);
      push_host(3, 9);
    join
    repeat (10) @(negedge clk);
    soft_rst_req = 1;
    @(negedge clk);
    soft_rst_req = 0;
    #1 check(!desc_ready, "R8", "desc_ready during reset", desc_ready, 0);
    hin_valid = 1; hin_data = 64'hDEAD_BEEF_DEAD_BEEF;
    repeat (20) @(negedge clk);
    hin_valid = 0;
    for (int t = 0; t < 2000 && !done; t++) begin @(negedge clk); done = soft_rst_done; end
    #1;
    check(soft_rst_done && desc_ready, "R8", "reset done flag", {soft_rst_done, desc_ready}, 2'b11);
    check(cpl_n == p0, "R8", "no completion for aborted", cpl_n - p0, 0);
    for (int i = 0; i < 8; i++) begin
      logic [63:0] e = (i < 3) ? pat_host(9, i) : pat_mem(64 + i);
      check(mem[10'(64 + i)] == e, "R8", "null-strobe finish", mem[10'(64 + i)], e);
    end
    soft_mode = 0;
    t_write(32'h200, 8, 11, 2'b00);
    check(soft_rst_done, "R8", "done flag held", soft_rst_done, 1);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = pat_mem(i);
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_read(32'h800, 5, 0, 2'b00);
    t_read(32'hF80, 24, 1, 2'b00);
    t_read(32'h1900, 2, 0, 2'b01);
    t_write(32'h100, 4, 1, 2'b00);
    t_write(32'hFC0, 20, 2, 2'b00);
    t_write(32'h400, 40, 3, 2'b00);
    t_write(32'h1800, 4, 4, 2'b01);
    t_align(32'h104, 32'h0, 16'd32);
    t_align(32'h100, 32'h3, 16'd32);
    t_align(32'h100, 32'h0, 16'd12);
    t_align(32'h100, 32'h0, 16'd0);
    t_softrst();
    check(id_bad == 0, "R4", "fixed id and burst attributes", id_bad, 0);
    check(wlast_bad == 0, "R2", "wlast placement", wlast_bad, 0);
    check(strb_bad == 0, "R2", "full strobes", strb_bad, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule